// File: doc/BRIEF.md
# Serial-Load Bank Switching Controller

This block is a cartridge-side bank controller that a CPU configures one bit at a time. Each CPU write into the upper half of the address space (address bit 15 set) shifts data bit 0 into a 5-bit loader. The fifth such write commits the assembled value into one of four configuration registers. Address bits 14:13 of that fifth write pick the register. A write with data bit 7 set abandons any partial load.

The configuration registers drive these outputs:
- the 16 KiB program bank numbers seen in the lower window (0x8000) and the upper window (0xC000),
- the nametable mirroring code,
- the character banking mode,
- two 5-bit character bank numbers for the 4 KiB windows.

The program mapping has three arrangements:
- lower window fixed at bank 0,
- upper window fixed at the last bank, where the last bank index is supplied as an input,
- a 32 KiB paired arrangement.

The bank outputs are derived combinationally from the stored registers. A change of mode therefore takes effect at once, using whatever program bank number is already held.

Top module: `serial_bank_ctrl`

## Requirements
- R1: After reset, the lower bank is 0, the upper bank equals `last_bank_i`, mirroring is 0, the character mode is 0, both character banks are 0, and the stored program bank number is 0.
- R2: A cycle without `wr_en_i`, or with address bit 15 clear, leaves the loader untouched. It neither shifts nor counts.
- R3: A counted write with data bit 7 set clears the loader and its write count. The next five writes then form a fresh value.
- R4: Data bit 0 of the first of five writes becomes bit 0 of the committed value, and so on up to the fifth write, which becomes bit 4. The fifth write commits using its own address bits 14:13: 00 = control, 01 = lower character bank, 10 = upper character bank, 11 = program bank. Data bits 6:1 are ignored.
- R5: Control bits 3:2 = 10 gives lower window bank 0 and upper window = program bank.
- R6: Control bits 3:2 = 11 gives lower window = program bank and upper window = `last_bank_i`.
- R7: Control bit 3 = 0 gives lower window = program bank with bit 0 cleared, and upper window = that value plus 1.
- R8: The program bank register keeps only the low 4 bits of the committed value. Bit 4 has no effect on the bank outputs.
- R9: Changing the mode re-applies the stored program bank number without rewriting it.
- R10: Control bits 1:0 appear on `mirror_o`, and control bit 4 appears on `chr_mode_o`.
- R11: Writes on consecutive cycles are each counted, with no filtering.
- R12: After a commit the loader starts empty, so the next five writes commit a second, independent value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | CPU write strobe, one cycle per write |
| addr_i | input | 16 | CPU write address |
| data_i | input | 8 | CPU write data |
| last_bank_i | input | 4 | Index of the last 16 KiB program bank |
| prg_lo_bank_o | output | 4 | Program bank mapped at 0x8000 |
| prg_hi_bank_o | output | 4 | Program bank mapped at 0xC000 |
| mirror_o | output | 2 | Nametable mirroring code |
| chr_mode_o | output | 1 | Character banking mode |
| chr_lo_bank_o | output | 5 | Character bank for the 4 KiB window at 0x0000 |
| chr_hi_bank_o | output | 5 | Character bank for the 4 KiB window at 0x1000 |

## Verification
The hardest state to reach from the ports is a loader holding a partial count. Nothing exposes the count directly, so an ignored write, a cleared load or a miscounted burst can only be seen through which register the next commit reaches and what value it carries. The bench therefore stages partial loads, then clears, ignored writes or back-to-back bursts, and then completes a full program-bank load. It checks the resulting bank outputs, which show whether the earlier writes were counted. Data bits 6:1 carry junk on every write, which shows that only bit 0 is sampled.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int SHIFT_W = 5;
  localparam int CNT_W   = $clog2(SHIFT_W);

  typedef enum logic [1:0] {
    SEL_CTRL   = 2'b00,
    SEL_CHR_LO = 2'b01,
    SEL_CHR_HI = 2'b10,
    SEL_PRG    = 2'b11
  } reg_sel_e;

  localparam logic [SHIFT_W-1:0] CTRL_RESET = 5'b01100;
endpackage

// File: rtl/sbc_loader.sv
module sbc_loader
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DATA_W-1:0]  data_i,
  output logic               commit_o,
  output reg_sel_e           sel_o,
  output logic [SHIFT_W-1:0] value_o
);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(SHIFT_W - 1);

  logic [SHIFT_W-1:0] shreg_q;
  logic [CNT_W-1:0]   cnt_q;
  logic               hit, clr, shifted_in;

  assign hit        = wr_en_i && addr_i[ADDR_W-1];
  assign clr        = data_i[DATA_W-1];
  assign shifted_in = data_i[0];
  assign value_o    = {shifted_in, shreg_q[SHIFT_W-1:1]};
  assign commit_o   = hit && !clr && (cnt_q == LAST_CNT);
  assign sel_o      = reg_sel_e'(addr_i[ADDR_W-2:ADDR_W-3]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
      cnt_q   <= '0;
    end else if (hit) begin
      if (clr || cnt_q == LAST_CNT) begin
        shreg_q <= '0;
        cnt_q   <= '0;
      end else begin
        shreg_q <= value_o;
        cnt_q   <= cnt_q + 1'b1;
      end
    end
  end

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST_CNT);
  assert_clear_on_bit7_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && clr) |=> (cnt_q == '0 && shreg_q == '0));
  assert_ignore_other_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |=> ($stable(cnt_q) && $stable(shreg_q)));
  assert_empty_after_commit_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |=> (cnt_q == '0));
endmodule

// File: rtl/sbc_reg_file.sv
module sbc_reg_file
  import sbc_pkg::*;
#(
  parameter int BANK_W = 4,
  parameter int CHR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               commit_i,
  input  reg_sel_e           sel_i,
  input  logic [SHIFT_W-1:0] value_i,
  output logic [SHIFT_W-1:0] ctrl_o,
  output logic [CHR_W-1:0]   chr_lo_o,
  output logic [CHR_W-1:0]   chr_hi_o,
  output logic [BANK_W-1:0]  prg_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o   <= CTRL_RESET;
      chr_lo_o <= '0;
      chr_hi_o <= '0;
      prg_o    <= '0;
    end else if (commit_i) begin
      unique case (sel_i)
        SEL_CTRL:   ctrl_o   <= value_i;
        SEL_CHR_LO: chr_lo_o <= CHR_W'(value_i);
        SEL_CHR_HI: chr_hi_o <= CHR_W'(value_i);
        SEL_PRG:    prg_o    <= value_i[BANK_W-1:0];
      endcase
    end
  end

  assert_ctrl_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(ctrl_o));
  assert_prg_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit_i && sel_i != SEL_PRG) |=> $stable(prg_o));
endmodule

// File: rtl/sbc_prg_map.sv
module sbc_prg_map #(
  parameter int BANK_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [BANK_W-1:0] prg_i,
  input  logic [BANK_W-1:0] last_bank_i,
  output logic [BANK_W-1:0] lo_o,
  output logic [BANK_W-1:0] hi_o
);
  logic [BANK_W-1:0] pair_base;
  assign pair_base = {prg_i[BANK_W-1:1], 1'b0};

  always_comb begin
    unique casez (mode_i)
      2'b0?: begin
        lo_o = pair_base;
        hi_o = pair_base | BANK_W'(1);
      end
      2'b10: begin
        lo_o = '0;
        hi_o = prg_i;
      end
      default: begin
        lo_o = prg_i;
        hi_o = last_bank_i;
      end
    endcase
  end

  assert_pair_adjacent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_i[1] |-> (lo_o[0] == 1'b0 && hi_o == lo_o + 1'b1));
  assert_fixed_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'b10) |-> (lo_o == '0));
endmodule

// File: rtl/serial_bank_ctrl.sv
module serial_bank_ctrl
  import sbc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int CHR_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic [BANK_W-1:0] last_bank_i,
  output logic [BANK_W-1:0] prg_lo_bank_o,
  output logic [BANK_W-1:0] prg_hi_bank_o,
  output logic [1:0]        mirror_o,
  output logic              chr_mode_o,
  output logic [CHR_W-1:0]  chr_lo_bank_o,
  output logic [CHR_W-1:0]  chr_hi_bank_o
);
  logic               commit;
  reg_sel_e           sel;
  logic [SHIFT_W-1:0] value, ctrl;
  logic [BANK_W-1:0]  prg;

  sbc_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_loader (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .data_i,
    .commit_o(commit), .sel_o(sel), .value_o(value)
  );

  sbc_reg_file #(.BANK_W(BANK_W), .CHR_W(CHR_W)) u_regs (
    .clk_i, .rst_ni, .commit_i(commit), .sel_i(sel), .value_i(value),
    .ctrl_o(ctrl), .chr_lo_o(chr_lo_bank_o), .chr_hi_o(chr_hi_bank_o), .prg_o(prg)
  );

  sbc_prg_map #(.BANK_W(BANK_W)) u_map (
    .clk_i, .rst_ni, .mode_i(ctrl[3:2]), .prg_i(prg), .last_bank_i,
    .lo_o(prg_lo_bank_o), .hi_o(prg_hi_bank_o)
  );

  assign mirror_o   = ctrl[1:0];
  assign chr_mode_o = ctrl[4];

  assert_prg_commit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && sel == SEL_PRG && ctrl[3:2] == 2'b11)
      |=> (prg_lo_bank_o == $past(value[BANK_W-1:0])));
  assert_last_fixed_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl[3:2] == 2'b11) |-> (prg_hi_bank_o == last_bank_i));
endmodule

// File: tb/sim_serial_bank_ctrl.sv
module sim_serial_bank_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic [3:0]  last_bank = 4'd7;
  logic [3:0]  lo, hi;
  logic [1:0]  mirror;
  logic        chr_mode;
  logic [4:0]  chr_lo, chr_hi;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  serial_bank_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .data_i(data),
    .last_bank_i(last_bank), .prg_lo_bank_o(lo), .prg_hi_bank_o(hi),
    .mirror_o(mirror), .chr_mode_o(chr_mode),
    .chr_lo_bank_o(chr_lo), .chr_hi_bank_o(chr_hi)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // single write with an idle cycle after; returns at negedge after the edge
  task automatic wr1(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load(logic [1:0] sel, logic [4:0] v);
    for (int i = 0; i < 5; i++)
      wr1({1'b1, sel, 13'h0A5}, {1'b0, 6'h2A ^ 6'(i), v[i]});
  endtask

  task automatic t_reset;
    check("R1 lo", lo, 0);
    check("R1 hi", hi, 7);
    check("R1 mirror", mirror, 0);
    check("R1 chr_mode", chr_mode, 0);
    check("R1 chr_lo", chr_lo, 0);
    check("R1 chr_hi", chr_hi, 0);
  endtask

  task automatic t_ignore;
    for (int i = 0; i < 4; i++) wr1(16'h7FFF, 8'h01);
    @(negedge clk); addr = 16'hE000; data = 8'h01; wr_en = 1'b0;
    @(negedge clk); @(negedge clk);
    check("R2 untouched", lo, 0);
    load(2'b11, 5'd5);
    check("R2 count unaffected", lo, 5);
  endtask

  task automatic t_clear;
    for (int i = 0; i < 3; i++) wr1(16'hE000, 8'h01);
    wr1(16'h8000, 8'h80);
    load(2'b11, 5'd3);
    check("R3 fresh value", lo, 3);
  endtask

  task automatic t_chr;
    load(2'b01, 5'h15);
    check("R4 chr_lo", chr_lo, 5'h15);
    check("R4 chr_hi unchanged", chr_hi, 0);
    load(2'b10, 5'h0A);
    check("R4 chr_hi", chr_hi, 5'h0A);
    check("R12 chr_lo kept", chr_lo, 5'h15);
  endtask

  task automatic t_modes;
    load(2'b11, 5'd9);
    check("R6 lo", lo, 9);
    check("R6 hi", hi, 7);
    last_bank = 4'd15;
    #1 check("R6 hi follows last", hi, 15);
    load(2'b00, 5'b01000);
    check("R5 lo", lo, 0);
    check("R9 R5 hi reapplied", hi, 9);
    load(2'b00, 5'b10010);
    check("R7 lo", lo, 8);
    check("R7 hi", hi, 9);
    check("R10 mirror", mirror, 2);
    check("R10 chr_mode", chr_mode, 1);
    load(2'b00, 5'b00111);
    check("R7 mode01 lo", lo, 8);
    check("R7 mode01 hi", hi, 9);
    check("R10 mirror3", mirror, 3);
    check("R10 chr_mode0", chr_mode, 0);
  endtask

  task automatic t_bit4;
    load(2'b00, 5'b01100);
    load(2'b11, 5'b10110);
    check("R8 bit4 dropped", lo, 6);
  endtask

  task automatic t_b2b;
    logic [4:0] v = 5'b01011;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      wr_en = 1'b1; addr = 16'hF123; data = {7'h3C, v[i]};
    end
    @(negedge clk); wr_en = 1'b0;
    check("R11 back-to-back", lo, 11);
    load(2'b11, 5'd2);
    check("R12 second commit", lo, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_ignore;
    t_clear;
    t_chr;
    t_modes;
    t_bit4;
    t_b2b;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule